// File: doc/BRIEF.md
# Scan Test Sequencer

This controller drives structural testing of a logic block whose flip-flops have been turned into mux-flops and linked into one serial chain. It takes test patterns from a valid/ready stream. Each item holds the bits to load into the chain, the primary-input values to apply, the expected captured response, a per-bit mask and a last-item flag. The controller shifts the load bits into the chain with scan enable high. It holds the primary inputs steady and then gives exactly one functional capture clock with scan enable low. During the next shift phase it compares the captured response, bit by bit, as that response leaves the chain, while the next pattern enters at the same time.

A clock-enable output stops the chain whenever the controller is waiting for stream data, so the captured state is held until it can be unloaded. After the item flagged last, one extra phase shifts zeros in, so that the final response can still be compared. The controller keeps a count of applied patterns. It latches the pattern index and the flop index of the first unmasked mismatch, and then stops in a done state until reset.

Top module: `scan_seq`

## Requirements
- R1: After reset, pat_ready is high, and fail, done, scan_ce and pat_cnt are all zero.
- R2: Each shift phase holds scan_en and scan_ce high for exactly CHAIN_LEN consecutive cycles. Chain flop 0 is nearest scan_si and flop CHAIN_LEN-1 drives scan_so. Load bits leave highest index first, so after the phase flop i holds pat_load[i].
- R3: Between a pattern's shift phase and the next phase, scan_ce is high with scan_en low for exactly one cycle. During that cycle pi_out equals the pattern's pat_pi.
- R4: While the controller waits for a stream item (pat_ready high), scan_ce is low and the chain contents do not change.
- R5: The response captured for pattern k is compared during the shift phase that loads pattern k+1. Flop i is compared with bit i of pattern k's pat_exp, from the highest index down.
- R6: A bit whose pat_mask bit is 1 never counts as a mismatch.
- R7: The first unmasked mismatch sets fail, with fail_pat holding the pattern index (counting from 0) and fail_bit holding the flop index. Later mismatches leave all three unchanged.
- R8: After the capture of the item with pat_last set, one more phase of CHAIN_LEN shifts feeds zeros and compares the last response. done then goes high and stays high with pat_ready low.
- R9: pat_cnt rises by exactly one at each capture cycle and never changes otherwise.
- R10: The first shift phase after reset compares nothing, whatever the chain held before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for controller and chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_valid | input | 1 | Stream item present |
| pat_ready | output | 1 | Controller accepts an item this cycle |
| pat_load | input | CHAIN_LEN | Bits to load, bit i into flop i |
| pat_pi | input | PI_W | Primary-input values for the capture |
| pat_exp | input | CHAIN_LEN | Expected captured response, bit i for flop i |
| pat_mask | input | CHAIN_LEN | 1 excludes that response bit from comparison |
| pat_last | input | 1 | Item is the final pattern |
| scan_en | output | 1 | 1 selects the serial path, 0 the functional input |
| scan_ce | output | 1 | Chain clock enable |
| scan_si | output | 1 | Serial data into flop 0 |
| scan_so | input | 1 | Serial data from flop CHAIN_LEN-1 |
| pi_out | output | PI_W | Primary inputs driven to the logic under test |
| fail | output | 1 | An unmasked mismatch has been seen |
| fail_pat | output | PAT_W | Pattern index of the first mismatch |
| fail_bit | output | IDX_W | Flop index of the first mismatch |
| pat_cnt | output | PAT_W | Number of captures performed |
| done | output | 1 | All patterns applied and final response checked |

## Verification
A stream item is accepted at a rising edge. The CHAIN_LEN shift edges follow directly, and the capture is the edge after that, which is also the edge where pat_cnt rises. Any mismatch is latched at the very edge that shifts the offending bit out. The bench drives and samples only at falling edges. A falling-edge monitor checks the phase length, the chain contents and pi_out in the capture cycle, and holding while waiting. Latched results are read only once done is observed high, so no check depends on counting edges in the bench.

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter int PAT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pat_valid,
  output logic                         pat_ready,
  input  logic [CHAIN_LEN-1:0]         pat_load,
  input  logic [PI_W-1:0]              pat_pi,
  input  logic [CHAIN_LEN-1:0]         pat_exp,
  input  logic [CHAIN_LEN-1:0]         pat_mask,
  input  logic                         pat_last,
  output logic                         scan_en,
  output logic                         scan_ce,
  output logic                         scan_si,
  input  logic                         scan_so,
  output logic [PI_W-1:0]              pi_out,
  output logic                         fail,
  output logic [PAT_W-1:0]             fail_pat,
  output logic [$clog2(CHAIN_LEN)-1:0] fail_bit,
  output logic [PAT_W-1:0]             pat_cnt,
  output logic                         done
);
  localparam int IDX_W = $clog2(CHAIN_LEN);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(CHAIN_LEN - 1);

  typedef enum logic [2:0] {S_WAIT, S_SHIFT, S_CAP, S_FLUSH, S_DONE} st_t;

  st_t                  st;
  logic [IDX_W-1:0]     cnt;
  logic [CHAIN_LEN-1:0] ld, exp_n, msk_n, exp_c, msk_c;
  logic [PI_W-1:0]      pi_q;
  logic                 last_n, primed, cmp_on;
  logic                 shifting, miss;

  assign pat_ready = (st == S_WAIT);
  assign shifting  = (st == S_SHIFT) || (st == S_FLUSH);
  assign scan_en   = (st != S_CAP);
  assign scan_ce   = shifting || (st == S_CAP);
  assign scan_si   = ld[cnt];
  assign pi_out    = pi_q;
  assign done      = (st == S_DONE);
  assign miss      = shifting && cmp_on && !msk_c[cnt] && (scan_so != exp_c[cnt]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_WAIT;
      cnt     <= '0;
      ld      <= '0;
      pi_q    <= '0;
      exp_n   <= '0;
      msk_n   <= '0;
      exp_c   <= '0;
      msk_c   <= '0;
      last_n  <= 1'b0;
      primed  <= 1'b0;
      cmp_on  <= 1'b0;
      pat_cnt <= '0;
    end else begin
      case (st)
        S_WAIT: if (pat_valid) begin
          ld     <= pat_load;
          pi_q   <= pat_pi;
          exp_n  <= pat_exp;
          msk_n  <= pat_mask;
          last_n <= pat_last;
          exp_c  <= exp_n;
          msk_c  <= msk_n;
          cmp_on <= primed;
          cnt    <= TOP;
          st     <= S_SHIFT;
        end
        S_SHIFT, S_FLUSH: begin
          if (cnt == '0) st <= (st == S_SHIFT) ? S_CAP : S_DONE;
          else           cnt <= cnt - 1'b1;
        end
        S_CAP: begin
          pat_cnt <= pat_cnt + 1'b1;
          primed  <= 1'b1;
          if (last_n) begin
            exp_c  <= exp_n;
            msk_c  <= msk_n;
            ld     <= '0;
            cmp_on <= 1'b1;
            cnt    <= TOP;
            st     <= S_FLUSH;
          end else begin
            st <= S_WAIT;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      fail_pat <= '0;
      fail_bit <= '0;
    end else if (miss && !fail) begin
      fail     <= 1'b1;
      fail_pat <= pat_cnt - 1'b1;
      fail_bit <= cnt;
    end
  end

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ce && !scan_en) |=> (scan_en || !scan_ce)); // R3
  AST_ACCEPT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && pat_ready) |=> (scan_en && scan_ce)); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ready |-> !scan_ce); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (fail && $stable(fail_pat) && $stable(fail_bit))); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pat_cnt) |-> (pat_cnt == $past(pat_cnt) + 1'b1)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !pat_ready)); // R8
endmodule

// File: tb/scan_seq_tb_top.sv
`timescale 1ns/1ps
module scan_seq_cut #(
  parameter int N = 8,
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         se,
  input  logic         si,
  input  logic [P-1:0] pi,
  output logic         so,
  output logic [N-1:0] q
);
  logic [N-1:0] d;
  always_comb
    for (int i = 0; i < N; i++) d[i] = q[(i + 1) % N] ^ (q[i] & pi[i % P]);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  q <= N'(8'hA5);
    else if (ce) q <= se ? {q[N-2:0], si} : d;
  assign so = q[N-1];
endmodule

module scan_seq_tb_top;
  localparam int N = 8;
  localparam int P = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_valid = 1'b0, pat_last = 1'b0;
  logic [N-1:0] pat_load = '0, pat_exp = '0, pat_mask = '0;
  logic [P-1:0] pat_pi = '0;
  logic pat_ready, scan_en, scan_ce, scan_si, scan_so, fail, done;
  logic [P-1:0] pi_out;
  logic [W-1:0] fail_pat, pat_cnt;
  logic [2:0] fail_bit;
  logic [N-1:0] q;

  always #2 clk = ~clk;

  scan_seq #(.CHAIN_LEN(N), .PI_W(P), .PAT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_load(pat_load), .pat_pi(pat_pi), .pat_exp(pat_exp), .pat_mask(pat_mask),
    .pat_last(pat_last), .scan_en(scan_en), .scan_ce(scan_ce), .scan_si(scan_si),
    .scan_so(scan_so), .pi_out(pi_out), .fail(fail), .fail_pat(fail_pat),
    .fail_bit(fail_bit), .pat_cnt(pat_cnt), .done(done));

  scan_seq_cut #(.N(N), .P(P)) cut_i (
    .clk(clk), .rst_n(rst_n), .ce(scan_ce), .se(scan_en), .si(scan_si),
    .pi(pi_out), .so(scan_so), .q(q));

  int total = 0, bad = 0;
  logic [N-1:0] ld_a [8], flip_a [8], msk_a [8];
  logic [P-1:0] pi_a [8];
  int gap_a [8];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] resp(input logic [N-1:0] s, input logic [P-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[(i + 1) % N] ^ (s[i] & v[i % P]);
    return r;
  endfunction

  // falling-edge monitor: phase length R2, load + pi at capture R2/R3, hold R4
  int run = 0, capi = 0;
  logic was_wait = 1'b0;
  logic [N-1:0] qprev = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0; capi = 0; was_wait = 1'b0;
    end else begin
      if (scan_ce && scan_en) run++;
      else if (run != 0) begin
        chk(run == N, "R2", "shift phase length", run, N);
        run = 0;
      end
      if (scan_ce && !scan_en) begin
        chk(q == ld_a[capi], "R2", "chain contents before capture", int'(q), int'(ld_a[capi]));
        chk(pi_out == pi_a[capi], "R3", "pi_out at capture", int'(pi_out), int'(pi_a[capi]));
        capi++;
      end
      if (pat_ready) begin
        chk(!scan_ce, "R4", "scan_ce while waiting", int'(scan_ce), 0);
        if (was_wait) chk(q == qprev, "R4", "chain held while waiting", int'(q), int'(qprev));
      end
      was_wait = pat_ready;
      qprev = q;
    end
  end

  task automatic do_reset();
    pat_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int p, input bit last);
    repeat (gap_a[p]) @(negedge clk);
    pat_load  = ld_a[p];
    pat_pi    = pi_a[p];
    pat_exp   = resp(ld_a[p], pi_a[p]) ^ flip_a[p];
    pat_mask  = msk_a[p];
    pat_last  = last;
    pat_valid = 1'b1;
    while (!pat_ready) @(negedge clk);
    @(negedge clk);
    pat_valid = 1'b0;
  endtask

  // runs n patterns and checks the latched outcome against the bench's own prediction
  task automatic run_set(input int n, input string tag);
    int efp, efb;
    bit ef;
    ef = 0; efp = 0; efb = 0;
    for (int p = 0; p < n; p++) send(p, p == n - 1);
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    chk(done, "R8", {tag, " done after flush"}, int'(done), 1);
    for (int p = 0; p < n && !ef; p++) begin
      logic [N-1:0] m;
      m = flip_a[p] & ~msk_a[p];
      if (m != '0) begin
        ef = 1; efp = p;
        for (int b = N - 1; b >= 0; b--) if (m[b]) begin efb = b; break; end
      end
    end
    chk(fail == ef, "R7", {tag, " fail flag"}, int'(fail), int'(ef));
    if (ef) begin
      chk(int'(fail_pat) == efp, "R7", {tag, " fail_pat"}, int'(fail_pat), efp);
      chk(int'(fail_bit) == efb, "R5", {tag, " fail_bit"}, int'(fail_bit), efb);
    end
    chk(int'(pat_cnt) == n, "R9", {tag, " pat_cnt"}, int'(pat_cnt), n);
    chk(capi == n, "R3", {tag, " capture cycles"}, capi, n);
    chk(q == '0, "R8", {tag, " zeros shifted in by flush"}, int'(q), 0);
    repeat (3) @(negedge clk);
    chk(done && !pat_ready, "R8", {tag, " done holds, ready low"}, int'(pat_ready), 0);
  endtask

  task automatic clear_sets();
    for (int p = 0; p < 8; p++) begin
      ld_a[p] = N'(8'h3C + 8'd37 * p);
      pi_a[p] = P'(4'h9 + 4'd5 * p);
      flip_a[p] = '0;
      msk_a[p] = '0;
      gap_a[p] = 0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(pat_ready, "R1", "pat_ready after reset", int'(pat_ready), 1);
    chk(!fail && !done, "R1", "fail/done after reset", int'({fail, done}), 0);
    chk(!scan_ce, "R1", "scan_ce after reset", int'(scan_ce), 0);
    chk(pat_cnt == '0, "R1", "pat_cnt after reset", int'(pat_cnt), 0);
  endtask

  task automatic t_clean();
    do_reset(); clear_sets();
    gap_a[1] = 3; gap_a[2] = 1;
    run_set(3, "clean R5 R10");
  endtask

  task automatic t_first_kept();
    do_reset(); clear_sets();
    flip_a[1] = 8'h24; flip_a[2] = 8'h40; gap_a[3] = 2;
    run_set(4, "first-kept R7");
  endtask

  task automatic t_mask_flush();
    do_reset(); clear_sets();
    flip_a[0] = 8'h08; msk_a[0] = 8'h08;
    flip_a[2] = 8'h01; msk_a[2] = 8'h02;
    run_set(3, "mask+flush R6 R8");
  endtask

  task automatic t_mask_all();
    do_reset(); clear_sets();
    flip_a[0] = 8'hFF; msk_a[0] = 8'hFF;
    flip_a[1] = 8'h81; msk_a[1] = 8'hFF;
    run_set(2, "fully masked R6");
  endtask

  task automatic t_single();
    do_reset(); clear_sets();
    flip_a[0] = 8'h80;
    run_set(1, "single R8");
  endtask

  initial begin
    t_reset();
    t_clean();
    t_first_kept();
    t_mask_flush();
    t_mask_all();
    t_single();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog run did not complete act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule